// File: doc/BRIEF.md
# Timed-Event Test Coprocessor

This block is a test peripheral that sits behind a processor's coprocessor handshake. It holds sixteen 32-bit registers and gives test software three services: a programmable stall, delayed interrupt injection, and time-stamp capture. The registers can be written and read by single-register transfers. They can also be loaded and stored one word per beat by memory transfers, which may be marked long.

Each command arrives as a one-cycle strobe with a kind code, a unit select, a 32-bit instruction word and a write-data word. The block answers one cycle later with a done, more-words or reject pulse. A stall command raises a busy line for a number of cycles taken from a register. Two schedule commands drive the active-low fast and normal interrupt lines low after a delay. Two release commands drive them high again. A stamp command copies a free-running 32-bit cycle counter into a register.

Unit select 0 is the full-function coprocessor number. Unit select 1 is the second number, which shares the register file but accepts only the stall among the data-processing commands.

Top module: `tcop_unit`

## Requirements
- R1: After reset, every register reads 0, `fiq_n` and `irq_n` are high, `resp_busy` is low, no response pulse is present, and `rd_data` is 0.
- R2: Kind 0 writes `op_wdata` into the register indexed by instruction bits [19:16], and kind 1 copies that register to `rd_data`. Both are accepted on either unit and answer with `resp_done` in the next cycle.
- R3: Kind 2 (load) writes `op_wdata` into the register indexed by bits [15:12], and kind 3 (store) copies that register to `rd_data`. On unit 1 both are rejected and change neither a register nor `rd_data`.
- R4: A load or store with bit 22 set is long. Its first LONG_BEATS-1 beats each answer `resp_more`, and the beat after them answers `resp_done` and ends the transfer. Without bit 22 a beat answers `resp_done` at once.
- R5: Data-processing command (kind 4) opcode 0, taken from bits [23:20], stalls. Let V be the register indexed by bits [3:0]. `resp_busy` is then high for exactly V cycles and falls together with a one-cycle `resp_done`. When V is 0, `resp_done` comes in the next cycle with no busy cycle. The stall works on both units.
- R6: A command presented while `resp_busy` is high is ignored. It produces no response and has no effect on the registers.
- R7: Opcode 1 drives `fiq_n` low V cycles after acceptance, and opcode 2 does the same for `irq_n`, with V taken from the operand register. When V is 0 the line goes low in the next cycle.
- R8: Each interrupt line has its own pending delay. A new schedule command on a line replaces any delay still pending on that line.
- R9: Opcode 3 drives `fiq_n` high and opcode 4 drives `irq_n` high in the next cycle. A pending delay keeps running and still drives the line low when it expires.
- R10: Opcode 5 writes the current value of the cycle counter into the operand register. The counter advances by one every cycle after reset and wraps modulo 2^32.
- R11: Kind 4 with an opcode above 5 on unit 0, kind 4 with any opcode other than 0 on unit 1, and kinds 5 to 7 are rejected. A rejected command answers `resp_reject` in the next cycle and has no other effect.
- R12: At most one of `resp_done`, `resp_more` and `resp_reject` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Command strobe, one cycle per command or beat |
| op_kind | input | 3 | Command kind: 0 write, 1 read, 2 load, 3 store, 4 data-processing |
| op_unit | input | 1 | Coprocessor number select: 0 full, 1 stall-only |
| op_insn | input | 32 | Instruction word carrying the indices, opcode and long flag |
| op_wdata | input | DATA_W | Data for register writes and loads |
| resp_busy | output | 1 | Stall in progress |
| resp_done | output | 1 | Command or final beat completed |
| resp_more | output | 1 | Long transfer wants a further beat |
| resp_reject | output | 1 | Command refused |
| rd_data | output | DATA_W | Result of the last read or store beat |
| fiq_n | output | 1 | Fast interrupt request, active low |
| irq_n | output | 1 | Normal interrupt request, active low |

## Verification
The bound checker watches, on every cycle, that responses stay mutually exclusive and that no response appears while a stall runs. It also checks that the busy line only falls together with a done pulse, that the cycle counter steps by one, that commands on the stall-only unit with a non-zero opcode are refused, and that a zero-delay fast-interrupt schedule takes effect in the next cycle. Only the bench scenarios can show the exact busy length and interrupt delay for non-zero values, the replacement of a pending schedule, the survival of a pending schedule across a release, the beat counting of long transfers, and the cycle distance between two time stamps.

// File: rtl/tcop_pkg.sv
// Shared types and instruction field positions for the timed-event test
// coprocessor. Assumes a 32-bit instruction word with fixed field places.
package tcop_pkg;

    localparam int INSN_W        = 32;
    localparam int MOVE_IDX_LSB  = 16;   // register index of single transfers
    localparam int MEM_IDX_LSB   = 12;   // register index of load/store beats
    localparam int OPC_LSB       = 20;   // data-processing opcode
    localparam int OPND_IDX_LSB  = 0;    // operand / target register index
    localparam int LONG_BIT      = 22;   // long load/store flag
    localparam int OPC_W         = 4;

    typedef enum logic [2:0] {
        K_WRITE = 3'd0,
        K_READ  = 3'd1,
        K_LOAD  = 3'd2,
        K_STORE = 3'd3,
        K_DPROC = 3'd4
    } op_kind_e;

    typedef enum logic [OPC_W-1:0] {
        DP_STALL   = 4'd0,
        DP_FIQ_SET = 4'd1,
        DP_IRQ_SET = 4'd2,
        DP_FIQ_CLR = 4'd3,
        DP_IRQ_CLR = 4'd4,
        DP_STAMP   = 4'd5
    } dp_op_e;

    typedef struct packed {
        logic reject;
        logic move_wr;
        logic move_rd;
        logic mem_wr;
        logic mem_rd;
        logic is_long;
        logic stall;
        logic fiq_set;
        logic irq_set;
        logic fiq_clr;
        logic irq_clr;
        logic stamp;
    } dec_t;

endpackage

// File: rtl/tcop_regfile.sv
// Register file: REG_CNT words of DATA_W bits, one synchronous write port
// and two combinational read ports. All words clear on reset.
module tcop_regfile #(
    parameter int DATA_W  = 32,
    parameter int REG_CNT = 16,
    localparam int IDX_W  = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [IDX_W-1:0]  rd_idx_a,
    output logic [DATA_W-1:0] rd_val_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [DATA_W-1:0] rd_val_b
);

    logic [DATA_W-1:0] words [REG_CNT];

    // Store one word per cycle; clear the whole file on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_CNT; i++) begin
                words[i] <= '0;
            end
        end else if (wr_en) begin
            words[wr_idx] <= wr_val;
        end
    end

    // Two independent read ports.
    assign rd_val_a = words[rd_idx_a];
    assign rd_val_b = words[rd_idx_b];

endmodule

// File: rtl/tcop_decode.sv
// Command decoder: turns kind, unit select and instruction word into one-hot
// actions. Purely combinational; the caller gates the result with acceptance.
module tcop_decode
    import tcop_pkg::*;
(
    input  logic [2:0]        kind,
    input  logic              unit,
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);

    logic [OPC_W-1:0] opc;
    assign opc = insn[OPC_LSB +: OPC_W];

    // Classify the command and flag everything that is not allowed.
    always_comb begin
        dec = '0;
        case (kind)
            K_WRITE: dec.move_wr = 1'b1;
            K_READ:  dec.move_rd = 1'b1;
            K_LOAD: begin
                if (unit) begin
                    dec.reject = 1'b1;
                end else begin
                    dec.mem_wr  = 1'b1;
                    dec.is_long = insn[LONG_BIT];
                end
            end
            K_STORE: begin
                if (unit) begin
                    dec.reject = 1'b1;
                end else begin
                    dec.mem_rd  = 1'b1;
                    dec.is_long = insn[LONG_BIT];
                end
            end
            K_DPROC: begin
                if (unit && opc != DP_STALL) begin
                    dec.reject = 1'b1;
                end else begin
                    case (opc)
                        DP_STALL:   dec.stall   = 1'b1;
                        DP_FIQ_SET: dec.fiq_set = 1'b1;
                        DP_IRQ_SET: dec.irq_set = 1'b1;
                        DP_FIQ_CLR: dec.fiq_clr = 1'b1;
                        DP_IRQ_CLR: dec.irq_clr = 1'b1;
                        DP_STAMP:   dec.stamp   = 1'b1;
                        default:    dec.reject  = 1'b1;
                    endcase
                end
            end
            default: dec.reject = 1'b1;
        endcase
    end

endmodule

// File: rtl/tcop_stall.sv
// Stall timer: on start it records the finish time as now + delay (modulo
// 2^DATA_W) and holds busy until the counter reaches it, then pulses fin.
// A zero delay pulses fin in the next cycle without any busy cycle.
// Assumes start is never raised while busy is high.
module tcop_stall #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] delay,
    input  logic [DATA_W-1:0] now,
    output logic              busy,
    output logic              fin
);

    logic [DATA_W-1:0] end_q;

    // Track the active stall and produce the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            fin   <= 1'b0;
            end_q <= '0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                if (delay == '0) begin
                    fin <= 1'b1;
                end else begin
                    busy  <= 1'b1;
                    end_q <= now + delay;
                end
            end else if (busy && now == end_q) begin
                busy <= 1'b0;
                fin  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tcop_evt_chan.sv
// One interrupt channel: an active-low request line with its own down-counter.
// A schedule replaces any pending count; a zero delay asserts at once.
// Release drives the line high but leaves a pending count running, and an
// expiry in the same cycle as a release wins.
module tcop_evt_chan #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sched,
    input  logic              release_i,
    input  logic [DATA_W-1:0] delay,
    output logic              req_n
);

    logic [DATA_W-1:0] left_q;

    // Count down the pending delay and drive the request line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_n  <= 1'b1;
            left_q <= '0;
        end else if (sched) begin
            if (delay == '0) begin
                req_n  <= 1'b0;
                left_q <= '0;
            end else begin
                left_q <= delay;
            end
        end else begin
            if (release_i) begin
                req_n <= 1'b1;
            end
            if (left_q != '0) begin
                left_q <= left_q - 1'b1;
                if (left_q == {{(DATA_W-1){1'b0}}, 1'b1}) begin
                    req_n <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/tcop_unit.sv
// Timed-event test coprocessor top. Accepts one command per cycle unless a
// stall is running, answers one cycle later, and drives two active-low
// interrupt lines. Assumes the requester issues beats of one long transfer
// back to back and waits out a busy stall before the next command.
module tcop_unit
    import tcop_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int REG_CNT    = 16,
    parameter int LONG_BEATS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_kind,
    input  logic              op_unit,
    input  logic [INSN_W-1:0] op_insn,
    input  logic [DATA_W-1:0] op_wdata,
    output logic              resp_busy,
    output logic              resp_done,
    output logic              resp_more,
    output logic              resp_reject,
    output logic [DATA_W-1:0] rd_data,
    output logic              fiq_n,
    output logic              irq_n
);

    localparam int IDX_W  = $clog2(REG_CNT);
    localparam int BEAT_W = (LONG_BEATS > 2) ? $clog2(LONG_BEATS) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(LONG_BEATS - 1);
    localparam int NCHAN  = 2;

    dec_t              dec;
    logic              acc;
    logic              stall_busy;
    logic              stall_fin;
    logic [DATA_W-1:0] cyc_q;
    logic [DATA_W-1:0] opnd_val;
    logic [DATA_W-1:0] xfer_val;
    logic              rf_we;
    logic [IDX_W-1:0]  rf_widx;
    logic [DATA_W-1:0] rf_wval;
    logic [IDX_W-1:0]  rf_ridx;
    logic [IDX_W-1:0]  move_idx, mem_idx, opnd_idx;
    logic              done_q, more_q, rej_q;
    logic [DATA_W-1:0] rd_q;
    logic [BEAT_W-1:0] beat_q;
    logic [NCHAN-1:0]  ch_set, ch_clr, ch_req_n;
    logic              unused_insn_bits;

    // Instruction bits that carry no meaning for this block.
    assign unused_insn_bits = ^{op_insn[INSN_W-1:24], op_insn[11:4]};

    // Decode the presented command.
    tcop_decode u_dec (
        .kind (op_kind),
        .unit (op_unit),
        .insn (op_insn),
        .dec  (dec)
    );

    assign acc      = op_valid && !stall_busy;
    assign move_idx = op_insn[MOVE_IDX_LSB +: IDX_W];
    assign mem_idx  = op_insn[MEM_IDX_LSB +: IDX_W];
    assign opnd_idx = op_insn[OPND_IDX_LSB +: IDX_W];

    // Select the write source: transfer data or the time stamp.
    always_comb begin
        rf_we   = acc && (dec.move_wr || dec.mem_wr || dec.stamp);
        rf_widx = dec.move_wr ? move_idx : (dec.mem_wr ? mem_idx : opnd_idx);
        rf_wval = dec.stamp ? cyc_q : op_wdata;
        rf_ridx = dec.move_rd ? move_idx : mem_idx;
    end

    tcop_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rf_we),
        .wr_idx   (rf_widx),
        .wr_val   (rf_wval),
        .rd_idx_a (rf_ridx),
        .rd_val_a (xfer_val),
        .rd_idx_b (opnd_idx),
        .rd_val_b (opnd_val)
    );

    tcop_stall #(.DATA_W(DATA_W)) u_stall (
        .clk   (clk),
        .rst_n (rst_n),
        .start (acc && dec.stall),
        .delay (opnd_val),
        .now   (cyc_q),
        .busy  (stall_busy),
        .fin   (stall_fin)
    );

    // Channel 0 is the fast request, channel 1 the normal request.
    assign ch_set = {acc && dec.irq_set, acc && dec.fiq_set};
    assign ch_clr = {acc && dec.irq_clr, acc && dec.fiq_clr};

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        tcop_evt_chan #(.DATA_W(DATA_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .sched     (ch_set[c]),
            .release_i (ch_clr[c]),
            .delay     (opnd_val),
            .req_n     (ch_req_n[c])
        );
    end

    // Free-running cycle counter, wraps modulo 2^DATA_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // Register the response pulses, read data and long-transfer beat count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            more_q <= 1'b0;
            rej_q  <= 1'b0;
            rd_q   <= '0;
            beat_q <= '0;
        end else begin
            done_q <= 1'b0;
            more_q <= 1'b0;
            rej_q  <= 1'b0;
            if (acc) begin
                if (dec.reject) begin
                    rej_q <= 1'b1;
                end else if ((dec.mem_wr || dec.mem_rd) && dec.is_long) begin
                    if (beat_q == LAST_BEAT) begin
                        done_q <= 1'b1;
                        beat_q <= '0;
                    end else begin
                        more_q <= 1'b1;
                        beat_q <= beat_q + 1'b1;
                    end
                end else if (!dec.stall) begin
                    done_q <= 1'b1;
                    if (dec.mem_wr || dec.mem_rd) begin
                        beat_q <= '0;
                    end
                end
                if (dec.move_rd || dec.mem_rd) begin
                    rd_q <= xfer_val;
                end
            end
        end
    end

    assign resp_busy   = stall_busy;
    assign resp_done   = done_q || stall_fin;
    assign resp_more   = more_q;
    assign resp_reject = rej_q;
    assign rd_data     = rd_q;
    assign fiq_n       = ch_req_n[0];
    assign irq_n       = ch_req_n[1];

endmodule

// File: rtl/tcop_unit_chk.sv
// Cycle-by-cycle checker for tcop_unit, attached through bind below.
module tcop_unit_chk
    import tcop_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        op_kind,
    input logic              op_unit,
    input logic [INSN_W-1:0] op_insn,
    input logic              resp_busy,
    input logic              resp_done,
    input logic              resp_more,
    input logic              resp_reject,
    input logic              fiq_n,
    input logic [DATA_W-1:0] cyc,
    input logic [DATA_W-1:0] opnd
);

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_done, resp_more, resp_reject})); // R12

    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(resp_busy) |-> resp_done); // R5

    AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        resp_busy |-> !(resp_done || resp_more || resp_reject)); // R6

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cyc == $past(cyc) + 1'b1); // R10

    AST_UNIT1_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !resp_busy && op_unit && op_kind == K_DPROC &&
         op_insn[OPC_LSB +: OPC_W] != 4'd0) |=> resp_reject); // R11

    AST_FIQ_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !resp_busy && !op_unit && op_kind == K_DPROC &&
         op_insn[OPC_LSB +: OPC_W] == 4'd1 && opnd == '0) |=> !fiq_n); // R7

endmodule

bind tcop_unit tcop_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_kind     (op_kind),
    .op_unit     (op_unit),
    .op_insn     (op_insn),
    .resp_busy   (resp_busy),
    .resp_done   (resp_done),
    .resp_more   (resp_more),
    .resp_reject (resp_reject),
    .fiq_n       (fiq_n),
    .cyc         (cyc_q),
    .opnd        (opnd_val)
);

// File: tb/tcop_unit_test.sv
module tcop_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = '0;
    logic        op_unit = 1'b0;
    logic [31:0] op_insn = '0;
    logic [31:0] op_wdata = '0;
    logic        resp_busy, resp_done, resp_more, resp_reject;
    logic [31:0] rd_data;
    logic        fiq_n, irq_n;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    tcop_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_unit(op_unit), .op_insn(op_insn), .op_wdata(op_wdata),
        .resp_busy(resp_busy), .resp_done(resp_done), .resp_more(resp_more),
        .resp_reject(resp_reject), .rd_data(rd_data), .fiq_n(fiq_n), .irq_n(irq_n)
    );

    // exp is {done, more, reject}
    typedef struct packed {
        logic [2:0]  kind;
        logic        unit;
        logic [31:0] insn;
        logic [31:0] wdata;
        logic [2:0]  exp;
        logic        chk_rd;
        logic [31:0] exp_rd;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 32'h0003_0000, 32'hDEAD_BEEF, 3'b100, 1'b0, 32'h0},        // R2
        '{3'd1, 1'b0, 32'h0003_0000, 32'h0,         3'b100, 1'b1, 32'hDEAD_BEEF}, // R2
        '{3'd0, 1'b1, 32'h0007_0000, 32'h0000_1234, 3'b100, 1'b0, 32'h0},        // R2
        '{3'd1, 1'b1, 32'h0007_0000, 32'h0,         3'b100, 1'b1, 32'h0000_1234}, // R2
        '{3'd2, 1'b0, 32'h0000_9000, 32'h0000_A5A5, 3'b100, 1'b0, 32'h0},        // R3
        '{3'd1, 1'b0, 32'h0009_0000, 32'h0,         3'b100, 1'b1, 32'h0000_A5A5}, // R3
        '{3'd3, 1'b0, 32'h0000_3000, 32'h0,         3'b100, 1'b1, 32'hDEAD_BEEF}, // R3
        '{3'd2, 1'b1, 32'h0000_3000, 32'h0,         3'b001, 1'b0, 32'h0},        // R3
        '{3'd3, 1'b1, 32'h0000_9000, 32'h0,         3'b001, 1'b1, 32'hDEAD_BEEF}, // R3
        '{3'd1, 1'b0, 32'h0003_0000, 32'h0,         3'b100, 1'b1, 32'hDEAD_BEEF}, // R3
        '{3'd4, 1'b1, 32'h0010_0000, 32'h0,         3'b001, 1'b0, 32'h0},        // R11
        '{3'd4, 1'b0, 32'h0060_0000, 32'h0,         3'b001, 1'b0, 32'h0},        // R11
        '{3'd5, 1'b0, 32'h0003_0000, 32'h0,         3'b001, 1'b0, 32'h0},        // R11
        '{3'd7, 1'b0, 32'h0003_0000, 32'h0,         3'b001, 1'b0, 32'h0},        // R11
        '{3'd1, 1'b0, 32'h0003_0000, 32'h0,         3'b100, 1'b1, 32'hDEAD_BEEF}, // R11
        '{3'd4, 1'b0, 32'h0030_0000, 32'h0,         3'b100, 1'b0, 32'h0},        // R9
        '{3'd4, 1'b0, 32'h0040_0000, 32'h0,         3'b100, 1'b0, 32'h0}         // R9
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one command at a negedge; return at the next negedge.
    task automatic do_op(input logic [2:0] k, input logic u, input logic [31:0] ins,
                         input logic [31:0] wd);
        op_valid = 1'b1; op_kind = k; op_unit = u; op_insn = ins; op_wdata = wd;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic wr_reg(input int idx, input logic [31:0] val);
        do_op(3'd0, 1'b0, 32'(idx) << 16, val);
    endtask

    function automatic logic [31:0] resp3();
        return {29'b0, resp_done, resp_more, resp_reject};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        logic [31:0] ta, tb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 fiq_n", {31'b0, fiq_n}, 32'd1);
        chk("R1 irq_n", {31'b0, irq_n}, 32'd1);
        chk("R1 busy", {31'b0, resp_busy}, 32'd0);
        chk("R1 responses", resp3(), 32'd0);
        chk("R1 rd_data", rd_data, 32'd0);
        do_op(3'd1, 1'b0, 32'h0005_0000, 32'h0);
        chk("R1 register cleared", rd_data, 32'd0);

        // Vector table walk: R2 R3 R9 R11 R12
        for (int i = 0; i < NV; i++) begin
            do_op(VECS[i].kind, VECS[i].unit, VECS[i].insn, VECS[i].wdata);
            chk($sformatf("R12 vector %0d response", i), resp3(), {29'b0, VECS[i].exp});
            if (VECS[i].chk_rd) chk($sformatf("vector %0d rd_data", i), rd_data, VECS[i].exp_rd);
        end

        // R5 stall of four cycles
        wr_reg(1, 32'd4);
        do_op(3'd4, 1'b0, 32'h0000_0001, 32'h0);
        n = 0;
        while (resp_busy && n < 50) begin n++; @(negedge clk); end
        chk("R5 busy cycles", n, 32'd4);
        chk("R5 done at end", resp3(), 32'd4);

        // R5 zero stall
        wr_reg(2, 32'd0);
        do_op(3'd4, 1'b0, 32'h0000_0002, 32'h0);
        chk("R5 zero stall busy", {31'b0, resp_busy}, 32'd0);
        chk("R5 zero stall done", resp3(), 32'd4);

        // R5 stall on unit 1
        wr_reg(1, 32'd2);
        do_op(3'd4, 1'b1, 32'h0000_0001, 32'h0);
        n = 0;
        while (resp_busy && n < 50) begin n++; @(negedge clk); end
        chk("R5 unit1 busy cycles", n, 32'd2);

        // R6 command ignored while busy
        wr_reg(1, 32'd3);
        do_op(3'd4, 1'b0, 32'h0000_0001, 32'h0);
        do_op(3'd0, 1'b0, 32'h0003_0000, 32'h0);
        chk("R6 no response while busy", resp3(), 32'd0);
        while (resp_busy) @(negedge clk);
        do_op(3'd1, 1'b0, 32'h0003_0000, 32'h0);
        chk("R6 register untouched", rd_data, 32'hDEAD_BEEF);

        // R10 time stamps eight cycles apart
        do_op(3'd4, 1'b0, 32'h0050_0004, 32'h0);
        chk("R10 stamp done", resp3(), 32'd4);
        repeat (7) @(negedge clk);
        do_op(3'd4, 1'b0, 32'h0050_0005, 32'h0);
        do_op(3'd1, 1'b0, 32'h0004_0000, 32'h0);
        ta = rd_data;
        do_op(3'd1, 1'b0, 32'h0005_0000, 32'h0);
        tb = rd_data;
        chk("R10 stamp distance", tb - ta, 32'd8);

        // R7 delayed fast request
        wr_reg(1, 32'd4);
        do_op(3'd4, 1'b0, 32'h0010_0001, 32'h0);
        n = 0;
        while (fiq_n && n < 50) begin n++; @(negedge clk); end
        chk("R7 fiq delay", n, 32'd4);
        do_op(3'd4, 1'b0, 32'h0030_0000, 32'h0);
        chk("R9 fiq released", {31'b0, fiq_n}, 32'd1);

        // R7 immediate normal request, R9 release
        do_op(3'd4, 1'b0, 32'h0020_0002, 32'h0);
        chk("R7 irq immediate", {31'b0, irq_n}, 32'd0);
        do_op(3'd4, 1'b0, 32'h0040_0000, 32'h0);
        chk("R9 irq released", {31'b0, irq_n}, 32'd1);

        // R8 second schedule replaces the pending one
        wr_reg(1, 32'd10);
        wr_reg(6, 32'd3);
        do_op(3'd4, 1'b0, 32'h0020_0001, 32'h0);
        do_op(3'd4, 1'b0, 32'h0020_0006, 32'h0);
        n = 0;
        while (irq_n && n < 50) begin n++; @(negedge clk); end
        chk("R8 replaced delay", n, 32'd3);
        do_op(3'd4, 1'b0, 32'h0040_0000, 32'h0);
        n = 0;
        for (int k = 0; k < 12; k++) begin
            if (!irq_n) n++;
            @(negedge clk);
        end
        chk("R8 old schedule gone", n, 32'd0);

        // R9 release keeps a pending delay running
        wr_reg(1, 32'd5);
        do_op(3'd4, 1'b0, 32'h0010_0001, 32'h0);
        do_op(3'd4, 1'b0, 32'h0030_0000, 32'h0);
        n = 0;
        while (fiq_n && n < 50) begin n++; @(negedge clk); end
        chk("R9 pending survives release", n, 32'd4);
        do_op(3'd4, 1'b0, 32'h0030_0000, 32'h0);

        // R4 long load of five beats, then short load, then long store
        for (int b = 1; b <= 5; b++) begin
            do_op(3'd2, 1'b0, 32'h0040_8000, 32'h100 + 32'(b));
            chk($sformatf("R4 load beat %0d", b), resp3(), (b < 5) ? 32'd2 : 32'd4);
        end
        do_op(3'd1, 1'b0, 32'h0008_0000, 32'h0);
        chk("R4 last loaded word", rd_data, 32'h105);
        do_op(3'd2, 1'b0, 32'h0000_8000, 32'h77);
        chk("R4 short load done", resp3(), 32'd4);
        for (int b = 1; b <= 5; b++) begin
            do_op(3'd3, 1'b0, 32'h0040_8000, 32'h0);
            chk($sformatf("R4 store beat %0d", b), resp3(), (b < 5) ? 32'd2 : 32'd4);
        end
        chk("R4 stored word", rd_data, 32'h77);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule